// File: doc/BRIEF.md
# Pixel-Doubling Image Buffer Readout

This block keeps a composite picture of 2^CMP_LOG2 x 2^CMP_LOG2 pixels and N_TILES small square snapshots of 2^TILE_LOG2 x 2^TILE_LOG2 pixels in on-chip synchronous RAM, every pixel PIX_W bits wide. An upstream producer fills the stores through a single-cycle write port. A display pipeline presents a screen coordinate every clock and receives the pixel for that coordinate one clock later.

The composite is drawn as a window twice its stored size. Each stored pixel covers a 2x2 block of screen positions. The snapshots are drawn at their native size, side by side in a horizontal strip. Every other screen position reads as zero. Window origins are parameters. In the full-size build, CMP_LOG2=7, TILE_LOG2=4 and N_TILES=4 give a 256x256 window over a 128x128 store and four 16x16 snapshots: 104448 bits of storage at 6 bits per pixel. The defaults are smaller so that the RAM arrays stay modest.

Top module: `dbl_img_buf`

## Requirements
- R1: For a screen position (sx, sy) inside the composite window, where CMP_X0 <= sx < CMP_X0 + 2*2^CMP_LOG2 and likewise for y from CMP_Y0, the output is the composite pixel at row (sy-CMP_Y0)>>1 and column (sx-CMP_X0)>>1. Each stored pixel therefore fills two adjacent columns and two adjacent rows.
- R2: For a position inside the snapshot strip, where TILE_X0 <= sx < TILE_X0 + N_TILES*2^TILE_LOG2 and TILE_Y0 <= sy < TILE_Y0 + 2^TILE_LOG2, the output comes from snapshot (sx-TILE_X0)>>TILE_LOG2. It is the pixel at row sy-TILE_Y0 and column (sx-TILE_X0) mod 2^TILE_LOG2 of that snapshot. If the two windows overlap, the composite takes precedence.
- R3: At every position outside both windows, the output is 0.
- R4: The pixel for the coordinate presented in one cycle appears on `pix_out` after the next rising edge. A new coordinate may be presented every cycle.
- R5: A write with `wr_sel` = 0 stores `wr_data` into the composite at linear address `wr_addr` = row*2^CMP_LOG2 + column.
- R6: A write with `wr_sel` = k+1, for k in 0..N_TILES-1, stores into snapshot k. The address is taken from the low 2*TILE_LOG2 bits of `wr_addr`, as row*2^TILE_LOG2 + column.
- R7: A write with `wr_sel` greater than N_TILES changes no stored pixel.
- R8: Suppose a coordinate reads the same location that is being written in the same cycle. The output then shows the old value. The new value is shown from the next read onward.
- R9: While `rst` is high, `pix_out` is 0 from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W | Store select: 0 composite, k+1 snapshot k |
| wr_addr | input | 2*CMP_LOG2 | Linear pixel address within the selected store |
| wr_data | input | PIX_W | Pixel value to store |
| scan_x | input | SCR_W | Screen column being scanned |
| scan_y | input | SCR_W | Screen row being scanned |
| pix_out | output | PIX_W | Pixel for the coordinate of the previous cycle |

## Verification
The bench builds the block with CMP_LOG2=4, TILE_LOG2=2, N_TILES=4 and 8-bit screen coordinates. The composite window starts at (4,2) and the snapshot strip at (40,6). With these values, every stored location can be written and every screen position in a 64x48 area can be read back in a few thousand cycles. The sweep covers all window edges, every doubled pixel pair, each of the four snapshots, and all three unused select codes. Coordinates are streamed one per cycle, so the single-cycle latency is checked at every position, including the cycle where a write and a read hit the same location.

// File: rtl/dbl_img_buf_pkg.sv
package dbl_img_buf_pkg;
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_CMP  = 2'd1,
        REG_TILE = 2'd2
    } region_e;
endpackage

// File: rtl/img_sync_ram.sv
module img_sync_ram #(
    parameter int AW = 8,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // read returns the contents before any same-cycle write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        rd <= mem[ra];
    end
endmodule

// File: rtl/img_wr_router.sv
module img_wr_router #(
    parameter int N_TILES = 4,
    parameter int SEL_W   = 3
) (
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    output logic               cmp_we,
    output logic [N_TILES-1:0] tile_we
);
    assign cmp_we = wr_en && (wr_sel == '0);

    for (genvar k = 0; k < N_TILES; k++) begin : g_we
        assign tile_we[k] = wr_en && (wr_sel == SEL_W'(k + 1));
    end
endmodule

// File: rtl/img_scan_locator.sv
module img_scan_locator
    import dbl_img_buf_pkg::*;
#(
    parameter int SCR_W     = 10,
    parameter int CMP_LOG2  = 5,
    parameter int TILE_LOG2 = 4,
    parameter int N_TILES   = 4,
    parameter int TI_W      = 2,
    parameter int CMP_X0    = 0,
    parameter int CMP_Y0    = 0,
    parameter int TILE_X0   = 80,
    parameter int TILE_Y0   = 0
) (
    input  logic [SCR_W-1:0]       scan_x,
    input  logic [SCR_W-1:0]       scan_y,
    output region_e                region,
    output logic [2*CMP_LOG2-1:0]  cmp_addr,
    output logic [2*TILE_LOG2-1:0] tile_addr,
    output logic [TI_W-1:0]        tile_idx
);
    localparam int CDIM = 1 << CMP_LOG2;
    localparam int TDIM = 1 << TILE_LOG2;

    logic [SCR_W-1:0] cx, cy, tx, ty;
    logic             in_cmp, in_tile;
    logic             unused_bits;

    assign cx = scan_x - SCR_W'(CMP_X0);
    assign cy = scan_y - SCR_W'(CMP_Y0);
    assign tx = scan_x - SCR_W'(TILE_X0);
    assign ty = scan_y - SCR_W'(TILE_Y0);

    assign in_cmp  = (scan_x >= SCR_W'(CMP_X0)) && (scan_x < SCR_W'(CMP_X0 + 2*CDIM))
                  && (scan_y >= SCR_W'(CMP_Y0)) && (scan_y < SCR_W'(CMP_Y0 + 2*CDIM));
    assign in_tile = (scan_x >= SCR_W'(TILE_X0)) && (scan_x < SCR_W'(TILE_X0 + N_TILES*TDIM))
                  && (scan_y >= SCR_W'(TILE_Y0)) && (scan_y < SCR_W'(TILE_Y0 + TDIM));

    // halving the offsets gives the 2x replication
    assign cmp_addr  = {cy[CMP_LOG2:1], cx[CMP_LOG2:1]};
    assign tile_addr = {ty[TILE_LOG2-1:0], tx[TILE_LOG2-1:0]};
    assign tile_idx  = tx[TILE_LOG2 +: TI_W];

    always_comb begin
        if (in_cmp) begin
            region = REG_CMP;
        end else if (in_tile) begin
            region = REG_TILE;
        end else begin
            region = REG_NONE;
        end
    end

    assign unused_bits = ^{cx, cy, tx, ty};
endmodule

// File: rtl/dbl_img_buf.sv
module dbl_img_buf
    import dbl_img_buf_pkg::*;
#(
    parameter int PIX_W     = 6,
    parameter int SCR_W     = 10,
    parameter int CMP_LOG2  = 5,
    parameter int TILE_LOG2 = 4,
    parameter int N_TILES   = 4,
    parameter int CMP_X0    = 0,
    parameter int CMP_Y0    = 0,
    parameter int TILE_X0   = 80,
    parameter int TILE_Y0   = 0,
    parameter int SEL_W     = $clog2(N_TILES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [2*CMP_LOG2-1:0] wr_addr,
    input  logic [PIX_W-1:0]      wr_data,
    input  logic [SCR_W-1:0]      scan_x,
    input  logic [SCR_W-1:0]      scan_y,
    output logic [PIX_W-1:0]      pix_out
);
    localparam int CMP_AW  = 2 * CMP_LOG2;
    localparam int TILE_AW = 2 * TILE_LOG2;
    localparam int TI_W    = (N_TILES > 1) ? $clog2(N_TILES) : 1;

    region_e                rd_region;
    region_e                region_q;
    logic [CMP_AW-1:0]      cmp_ra;
    logic [TILE_AW-1:0]     tile_ra;
    logic [TI_W-1:0]        tile_sel;
    logic [TI_W-1:0]        tile_sel_q;
    logic                   cmp_we;
    logic [N_TILES-1:0]     tile_we;
    logic [PIX_W-1:0]       cmp_rd;
    logic [PIX_W-1:0]       tile_rd [N_TILES];

    img_scan_locator #(
        .SCR_W(SCR_W), .CMP_LOG2(CMP_LOG2), .TILE_LOG2(TILE_LOG2),
        .N_TILES(N_TILES), .TI_W(TI_W), .CMP_X0(CMP_X0), .CMP_Y0(CMP_Y0),
        .TILE_X0(TILE_X0), .TILE_Y0(TILE_Y0)
    ) u_loc (
        .scan_x(scan_x), .scan_y(scan_y), .region(rd_region),
        .cmp_addr(cmp_ra), .tile_addr(tile_ra), .tile_idx(tile_sel)
    );

    img_wr_router #(.N_TILES(N_TILES), .SEL_W(SEL_W)) u_wr (
        .wr_en(wr_en), .wr_sel(wr_sel), .cmp_we(cmp_we), .tile_we(tile_we)
    );

    img_sync_ram #(.AW(CMP_AW), .DW(PIX_W)) u_cmp_ram (
        .clk(clk), .we(cmp_we), .wa(wr_addr), .wd(wr_data),
        .ra(cmp_ra), .rd(cmp_rd)
    );

    for (genvar k = 0; k < N_TILES; k++) begin : g_tile
        img_sync_ram #(.AW(TILE_AW), .DW(PIX_W)) u_tile_ram (
            .clk(clk), .we(tile_we[k]), .wa(wr_addr[TILE_AW-1:0]), .wd(wr_data),
            .ra(tile_ra), .rd(tile_rd[k])
        );
    end

    // region and snapshot index travel alongside the RAM read
    always_ff @(posedge clk) begin
        if (rst) begin
            region_q   <= REG_NONE;
            tile_sel_q <= '0;
        end else begin
            region_q   <= rd_region;
            tile_sel_q <= tile_sel;
        end
    end

    always_comb begin
        unique case (region_q)
            REG_CMP:  pix_out = cmp_rd;
            REG_TILE: pix_out = tile_rd[tile_sel_q];
            default:  pix_out = '0;
        endcase
    end
endmodule

// File: rtl/dbl_img_buf_chk.sv
module dbl_img_buf_chk #(
    parameter int PIX_W     = 6,
    parameter int SCR_W     = 10,
    parameter int CMP_LOG2  = 5,
    parameter int TILE_LOG2 = 4,
    parameter int N_TILES   = 4,
    parameter int CMP_X0    = 0,
    parameter int CMP_Y0    = 0,
    parameter int TILE_X0   = 80,
    parameter int TILE_Y0   = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [SCR_W-1:0] scan_x,
    input logic [SCR_W-1:0] scan_y,
    input logic [PIX_W-1:0] pix_out
);
    localparam int CDIM = 1 << CMP_LOG2;
    localparam int TDIM = 1 << TILE_LOG2;

    logic             now_cmp, now_tile, now_even;
    logic             q_valid, q_wr, q_cmp, q_any, q_even;
    logic [SCR_W-1:0] q_sx, q_sy;
    logic [SCR_W-1:0] dx;

    assign dx       = scan_x - SCR_W'(CMP_X0);
    assign now_even = ~dx[0];
    assign now_cmp  = (int'(scan_x) >= CMP_X0) && (int'(scan_x) < CMP_X0 + 2*CDIM)
                   && (int'(scan_y) >= CMP_Y0) && (int'(scan_y) < CMP_Y0 + 2*CDIM);
    assign now_tile = (int'(scan_x) >= TILE_X0) && (int'(scan_x) < TILE_X0 + N_TILES*TDIM)
                   && (int'(scan_y) >= TILE_Y0) && (int'(scan_y) < TILE_Y0 + TDIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_wr    <= 1'b0;
            q_cmp   <= 1'b0;
            q_any   <= 1'b0;
            q_even  <= 1'b0;
            q_sx    <= '0;
            q_sy    <= '0;
        end else begin
            q_valid <= 1'b1;
            q_wr    <= wr_en;
            q_cmp   <= now_cmp;
            q_any   <= now_cmp || now_tile;
            q_even  <= now_even;
            q_sx    <= scan_x;
            q_sy    <= scan_y;
        end
    end

    AST_RESET_BLANK: assert property (@(posedge clk)
        rst |=> (pix_out == '0)); // R9

    AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_any) |-> (pix_out == '0)); // R3

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_wr && scan_x == q_sx && scan_y == q_sy) |=> $stable(pix_out)); // R4

    AST_DOUBLE_COLUMN: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_wr && q_cmp && now_cmp && q_even && scan_y == q_sy
         && scan_x == q_sx + SCR_W'(1)) |=> $stable(pix_out)); // R1
endmodule

bind dbl_img_buf dbl_img_buf_chk #(
    .PIX_W(PIX_W), .SCR_W(SCR_W), .CMP_LOG2(CMP_LOG2), .TILE_LOG2(TILE_LOG2),
    .N_TILES(N_TILES), .CMP_X0(CMP_X0), .CMP_Y0(CMP_Y0),
    .TILE_X0(TILE_X0), .TILE_Y0(TILE_Y0)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .scan_x(scan_x), .scan_y(scan_y), .pix_out(pix_out)
);

// File: tb/dbl_img_buf_tb.sv
`timescale 1ns/1ps
module dbl_img_buf_tb;
    localparam int PIX_W = 6, SCR_W = 8, CL = 4, TL = 2, NT = 4;
    localparam int CX0 = 4, CY0 = 2, TX0 = 40, TY0 = 6;
    localparam int CD = 1 << CL, TD = 1 << TL, SEL_W = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [SEL_W-1:0]   wr_sel = '0;
    logic [2*CL-1:0]    wr_addr = '0;
    logic [PIX_W-1:0]   wr_data = '0;
    logic [SCR_W-1:0]   scan_x = '0;
    logic [SCR_W-1:0]   scan_y = '0;
    logic [PIX_W-1:0]   pix_out;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int cmp_m [CD*CD];
    int tile_m [NT][TD*TD];

    always #10 clk = ~clk;

    dbl_img_buf #(
        .PIX_W(PIX_W), .SCR_W(SCR_W), .CMP_LOG2(CL), .TILE_LOG2(TL), .N_TILES(NT),
        .CMP_X0(CX0), .CMP_Y0(CY0), .TILE_X0(TX0), .TILE_Y0(TY0)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .scan_x(scan_x), .scan_y(scan_y), .pix_out(pix_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pix(input int sx, input int sy);
        if (sx >= CX0 && sx < CX0 + 2*CD && sy >= CY0 && sy < CY0 + 2*CD)
            return cmp_m[((sy - CY0) / 2) * CD + (sx - CX0) / 2];
        if (sx >= TX0 && sx < TX0 + NT*TD && sy >= TY0 && sy < TY0 + TD)
            return tile_m[(sx - TX0) / TD][(sy - TY0) * TD + (sx - TX0) % TD];
        return 0;
    endfunction

    function automatic string tag_of(input int sx, input int sy);
        if (sx >= CX0 && sx < CX0 + 2*CD && sy >= CY0 && sy < CY0 + 2*CD)
            return "R1 R4 R5";
        if (sx >= TX0 && sx < TX0 + NT*TD && sy >= TY0 && sy < TY0 + TD)
            return "R2 R4 R6";
        return "R3 R4";
    endfunction

    task automatic wr(input int sel, input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = SEL_W'(sel); wr_addr = (2*CL)'(a); wr_data = PIX_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: output blank while held in reset, even on a composite coordinate
        scan_x = SCR_W'(CX0); scan_y = SCR_W'(CY0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 reset blank", int'(pix_out), 0);
        end
        rst = 1'b0;

        for (int a = 0; a < CD*CD; a++) begin
            cmp_m[a] = (a * 7 + 3) % 64;
            wr(0, a, cmp_m[a]);
        end
        for (int t = 0; t < NT; t++) begin
            for (int a = 0; a < TD*TD; a++) begin
                tile_m[t][a] = (t * 21 + a * 5 + 1) % 64;
                wr(t + 1, a, tile_m[t][a]);
            end
        end
        // R7: unused select codes must leave every store untouched
        for (int s = NT + 1; s < 8; s++) begin
            for (int a = 0; a < TD*TD; a++) wr(s, a, 63);
        end
        @(negedge clk); scan_x = SCR_W'(CX0); scan_y = SCR_W'(CY0);
        @(negedge clk); chk("R7 composite untouched", int'(pix_out), cmp_m[0]);
        for (int t = 0; t < NT; t++) begin
            scan_x = SCR_W'(TX0 + t*TD); scan_y = SCR_W'(TY0);
            @(negedge clk); chk("R7 snapshot untouched", int'(pix_out), tile_m[t][0]);
        end

        // streamed sweep: one coordinate per cycle, checked a cycle later
        begin
            int px = -1, py = -1;
            for (int sy = 0; sy < 48; sy++) begin
                for (int sx = 0; sx < 64; sx++) begin
                    @(negedge clk);
                    if (px >= 0) chk(tag_of(px, py), int'(pix_out), exp_pix(px, py));
                    scan_x = SCR_W'(sx); scan_y = SCR_W'(sy);
                    px = sx; py = sy;
                end
            end
            @(negedge clk);
            chk(tag_of(px, py), int'(pix_out), exp_pix(px, py));
        end

        // R8: read and write of the same composite location in one cycle
        begin
            int a = 5 * CD + 3;
            int nv = (cmp_m[a] + 17) % 64;
            @(negedge clk);
            scan_x = SCR_W'(CX0 + 2*3 + 1); scan_y = SCR_W'(CY0 + 2*5 + 1);
            wr_en = 1'b1; wr_sel = '0; wr_addr = (2*CL)'(a); wr_data = PIX_W'(nv);
            @(negedge clk);
            wr_en = 1'b0;
            chk("R8 old value on collision", int'(pix_out), cmp_m[a]);
            cmp_m[a] = nv;
            @(negedge clk);
            chk("R8 new value next read", int'(pix_out), nv);
        end

        // R9: reset asserted mid-scan blanks the output
        scan_x = SCR_W'(CX0); scan_y = SCR_W'(CY0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); chk("R9 blank after reset", int'(pix_out), 0);
        rst = 1'b0;
        @(negedge clk); chk("R1 after reset release", int'(pix_out), cmp_m[0]);

        finish_run();
    end
endmodule